// File: doc/BRIEF.md
# Frequency-Trim Serial Register Slave

This block is a two-wire serial bus target that gives a bus master access to four byte-wide registers. Two of them hold a signed frequency trim word together with a bit that freezes the temperature compensation. The other two return a held copy of the live temperature code. The trim word and the freeze bit go out as plain signals to a compensation engine. After each write of the low trim byte, the block sends that engine a one-cycle recalculation strobe.

The bus lines are sampled by a fast system clock. Each line passes through a synchronizer and a majority-free glitch filter before START, STOP and clock edges are found. A write transaction first loads the register pointer. Each data byte that follows is stored at the pointer, and the pointer then advances. A read transaction returns bytes from the current pointer until the master answers NACK.

The temperature copy is taken at one moment only: when the word-address byte of a write arrives. Because of this, a single multi-byte read always returns a matching upper and lower temperature part.

Top module: `fxo_tune_i2c_slave`

## Requirements
- R1: The target answers only the 7-bit address 1000001 and ACKs the bytes 82h (write) and 83h (read). Any other address gets no ACK, and the target ignores all bus traffic until the next START.
- R2: In a write, the first byte after the address loads the register pointer. Only its two low bits are kept, so word address 05h selects register 01h.
- R3: Each further write data byte is stored at the pointer and ACKed, and then the pointer advances. The pointer goes from 03h back to 00h.
- R4: A read starts at the pointer left by the previous transaction, including a write or a read that ended earlier. It advances after every byte sent and also wraps from 03h to 00h. A repeated START may follow a pointer write.
- R5: A read ends when the master sends NACK, and the target then leaves SDA released. The target's SDA drive changes only while SCL is low.
- R6: Register 00h bit 7 drives `comp_hold`. Bits 6..0 of 00h drive `tune_word[14:8]`, and bit 6 is the sign of the 15-bit two's-complement word. Register 01h drives `tune_word[7:0]`.
- R7: After reset, registers 00h and 01h read 00h and the temperature copy reads 19h at 02h and 00h at 03h. This is the +25 °C code 190h.
- R8: The 12-bit temperature code is copied only when the word-address byte of a write is received. Register 02h returns code bits 11..4. Register 03h returns code bits 3..0 in its upper nibble and zero in its lower nibble. Changes on `temp_live` at any other time do not change what is read back.
- R9: Writes to 02h and 03h are ACKed but change nothing.
- R10: `tune_updated` is high for exactly one cycle after each write to 01h and never after a write to another register.
- R11: Pulses on SCL or SDA shorter than the filter length (3 system clocks) have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain drive) |
| temp_live | input | 12 | Live temperature code, two's complement, 1/16 °C |
| tune_word | output | 15 | Signed trim word to the compensation engine |
| comp_hold | output | 1 | Freeze temperature compensation |
| tune_updated | output | 1 | One-cycle strobe after a write to register 01h |

## Verification
The bench uses the default parameters: a two-stage synchronizer, a three-sample filter and the 1000001 address. The master model uses a 16-clock quarter bit. With this timing, every filtered edge settles well inside one SCL phase, and a two-clock spike on either line falls below the filter length. Injecting such spikes while SCL is high would create false clock edges and false START or STOP conditions if the filter were missing, so the trim readback after a spiked byte shows whether R11 holds. The pointer is walked through wrap-around, an out-of-range word address, a repeated START and reads left across transactions. The temperature input changes after each capture, which shows that the read values depend only on the capture moment.

// File: rtl/fxo_i2c_pkg.sv
package fxo_i2c_pkg;
   localparam int unsigned FXO_REG_CNT = 4;
   localparam int unsigned FXO_PTR_W   = $clog2(FXO_REG_CNT);
   localparam int unsigned FXO_BYTE_W  = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } bus_state_e;

   typedef enum logic [1:0] {
      BY_ADDR,
      BY_WORD,
      BY_DATA
   } byte_kind_e;
endpackage

// File: rtl/fxo_line_filter.sv
module fxo_line_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3,
   parameter bit          GLITCH_FILT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fxo_line_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("fxo_line_filter: FILT_LEN must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   if (GLITCH_FILT) begin : g_filter
      logic [FILT_LEN-1:0] win_q;
      logic                out_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q <= '1;
            out_q <= 1'b1;
         end else begin
            win_q <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&win_q)       out_q <= 1'b1;
            else if (~|win_q) out_q <= 1'b0;
         end
      end
      assign line_o = out_q;
   end else begin : g_bypass
      assign line_o = sync_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/fxo_i2c_engine.sv
module fxo_i2c_engine
   import fxo_i2c_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'h41
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_f,
   input  logic                  sda_f,
   output logic                  sda_oe,
   output logic [FXO_PTR_W-1:0]  ptr,
   input  logic [FXO_BYTE_W-1:0] rd_data,
   output logic                  wr_en,
   output logic [FXO_PTR_W-1:0]  wr_addr,
   output logic [FXO_BYTE_W-1:0] wr_data,
   output logic                  snap_en
);
   localparam logic [3:0] BITS_PER_BYTE = 4'(FXO_BYTE_W);

   bus_state_e            state;
   byte_kind_e            kind;
   logic                  scl_q, sda_q;
   logic [FXO_BYTE_W-1:0] sh;
   logic [3:0]            cnt;
   logic                  mack;

   logic scl_rise, scl_fall, start_c, stop_c;
   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         kind    <= BY_ADDR;
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
         sh      <= '0;
         cnt     <= '0;
         mack    <= 1'b0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         snap_en <= 1'b0;
      end else begin
         scl_q   <= scl_f;
         sda_q   <= sda_f;
         wr_en   <= 1'b0;
         snap_en <= 1'b0;
         if (start_c) begin
            state  <= ST_RX;
            kind   <= BY_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     sh  <= {sh[FXO_BYTE_W-2:0], sda_f};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == BITS_PER_BYTE) begin
                     cnt <= '0;
                     case (kind)
                        BY_ADDR: begin
                           if (sh[7:1] == SLAVE_ADDR) begin
                              sda_oe <= 1'b1;
                              state  <= ST_ACK;
                              kind   <= sh[0] ? BY_ADDR : BY_WORD;
                           end else begin
                              state  <= ST_IDLE;
                           end
                        end
                        BY_WORD: begin
                           ptr     <= sh[FXO_PTR_W-1:0];
                           snap_en <= 1'b1;
                           sda_oe  <= 1'b1;
                           state   <= ST_ACK;
                           kind    <= BY_DATA;
                        end
                        default: begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= sh;
                           ptr     <= ptr + 1'b1;
                           sda_oe  <= 1'b1;
                           state   <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (kind == BY_ADDR) begin
                        sh     <= rd_data;
                        sda_oe <= ~rd_data[FXO_BYTE_W-1];
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == BITS_PER_BYTE - 4'd1) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                        state  <= ST_MACK;
                     end else begin
                        sh     <= {sh[FXO_BYTE_W-2:0], 1'b0};
                        sda_oe <= ~sh[FXO_BYTE_W-2];
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_f;
                  end else if (scl_fall) begin
                     if (mack) begin
                        sh     <= rd_data;
                        sda_oe <= ~rd_data[FXO_BYTE_W-1];
                        state  <= ST_TX;
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

   // R5: the target is released whenever it is idle
   p_idle_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R5: drive changes only while SCL is low (bus conditions excepted)
   p_oe_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && scl_q && !$past(start_c || stop_c)) |-> $stable(sda_oe));

   // R3: a data store and a temperature capture never share a byte
   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && snap_en));
endmodule

// File: rtl/fxo_tune_regbank.sv
module fxo_tune_regbank
   import fxo_i2c_pkg::*;
#(
   parameter int unsigned          TEMP_W   = 12,
   parameter logic [TEMP_W-1:0]    TEMP_RST = 12'h190
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [FXO_PTR_W-1:0]  wr_addr,
   input  logic [FXO_BYTE_W-1:0] wr_data,
   input  logic                  snap_en,
   input  logic [TEMP_W-1:0]     temp_live,
   input  logic [FXO_PTR_W-1:0]  rd_ptr,
   output logic [FXO_BYTE_W-1:0] rd_data,
   output logic [14:0]           tune_word,
   output logic                  comp_hold,
   output logic                  tune_updated
);
   if (TEMP_W < 9 || TEMP_W > 16) begin : g_bad_temp
      $error("fxo_tune_regbank: TEMP_W must lie in 9..16");
   end

   localparam int unsigned PAD_W = 16 - TEMP_W;

   logic [FXO_BYTE_W-1:0] trim_hi, trim_lo;
   logic [TEMP_W-1:0]     temp_snap;
   logic [15:0]           snap_pad;

   assign snap_pad = 16'(temp_snap) << PAD_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim_hi      <= '0;
         trim_lo      <= '0;
         temp_snap    <= TEMP_RST;
         tune_updated <= 1'b0;
      end else begin
         tune_updated <= 1'b0;
         if (snap_en) temp_snap <= temp_live;
         if (wr_en) begin
            if (wr_addr == FXO_PTR_W'(0)) begin
               trim_hi <= wr_data;
            end else if (wr_addr == FXO_PTR_W'(1)) begin
               trim_lo      <= wr_data;
               tune_updated <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      case (rd_ptr)
         FXO_PTR_W'(0): rd_data = trim_hi;
         FXO_PTR_W'(1): rd_data = trim_lo;
         FXO_PTR_W'(2): rd_data = snap_pad[15:8];
         default:       rd_data = snap_pad[7:0];
      endcase
   end

   assign tune_word = {trim_hi[6:0], trim_lo};
   assign comp_hold = trim_hi[7];

   // R8: the copy moves only on a capture strobe
   p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_en |=> $stable(temp_snap));

   // R10: the recalculation strobe lasts one cycle
   p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tune_updated |=> !tune_updated);
endmodule

// File: rtl/fxo_tune_i2c_slave.sv
module fxo_tune_i2c_slave
   import fxo_i2c_pkg::*;
#(
   parameter logic [6:0]        SLAVE_ADDR  = 7'h41,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       FILT_LEN    = 3,
   parameter bit                GLITCH_FILT = 1'b1,
   parameter int unsigned       TEMP_W      = 12,
   parameter logic [TEMP_W-1:0] TEMP_RST    = 12'h190
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [TEMP_W-1:0] temp_live,
   output logic [14:0]       tune_word,
   output logic              comp_hold,
   output logic              tune_updated
);
   localparam int unsigned N_LINES = 2;

   logic [N_LINES-1:0]    raw_lines, filt_lines;
   logic [FXO_PTR_W-1:0]  ptr, wr_addr;
   logic [FXO_BYTE_W-1:0] rd_data, wr_data;
   logic                  wr_en, snap_en;

   assign raw_lines = {scl_i, sda_i};

   for (genvar li = 0; li < N_LINES; li++) begin : g_line
      fxo_line_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_LEN    (FILT_LEN),
         .GLITCH_FILT (GLITCH_FILT)
      ) i_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_lines[li]),
         .line_o (filt_lines[li])
      );
   end

   fxo_i2c_engine #(
      .SLAVE_ADDR (SLAVE_ADDR)
   ) i_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (filt_lines[1]),
      .sda_f   (filt_lines[0]),
      .sda_oe  (sda_oe),
      .ptr     (ptr),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .snap_en (snap_en)
   );

   fxo_tune_regbank #(
      .TEMP_W   (TEMP_W),
      .TEMP_RST (TEMP_RST)
   ) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .snap_en      (snap_en),
      .temp_live    (temp_live),
      .rd_ptr       (ptr),
      .rd_data      (rd_data),
      .tune_word    (tune_word),
      .comp_hold    (comp_hold),
      .tune_updated (tune_updated)
   );
endmodule

// File: tb/test_fxo_tune_i2c_slave.sv
module test_fxo_tune_i2c_slave;
   localparam int Q = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [11:0] temp_live = 12'h000;
   logic        sda_oe, comp_hold, tune_updated, sda_line;
   logic [14:0] tune_word;

   int n_chk = 0, n_bad = 0, pulse_cnt = 0, oe_viol = 0;
   logic       oe_prev = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] rd_byte;
   event       rd_ev;

   always #2 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   fxo_tune_i2c_slave i_fxo_tune_i2c_slave (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_line),
      .sda_oe       (sda_oe),
      .temp_live    (temp_live),
      .tune_word    (tune_word),
      .comp_hold    (comp_hold),
      .tune_updated (tune_updated)
   );

   always @(negedge clk) begin
      if (rst_n && tune_updated) pulse_cnt++;
      if (rst_n && sda_oe !== oe_prev && scl_m) oe_viol++;
      oe_prev = sda_oe;
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: compares each byte read from the bus
   initial begin
      forever begin
         @(rd_ev);
         if (exp_q.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R4 actual=%0h expected=none", rd_byte);
         end else begin
            check(tag_q.pop_front(), 32'(rd_byte), 32'(exp_q.pop_front()));
         end
      end
   end

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b1; wait_clk(Q);
   endtask

   task automatic wbyte(input logic [7:0] b, input bit spike, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_clk(Q);
         scl_m = 1'b1;
         if (spike && i == 3) begin
            wait_clk(Q / 2);
            scl_m = 1'b0; wait_clk(2);
            scl_m = 1'b1; wait_clk(Q / 2);
            sda_m = ~sda_m; wait_clk(2);
            sda_m = ~sda_m; wait_clk(Q);
         end else begin
            wait_clk(2 * Q);
         end
         scl_m = 1'b0; wait_clk(Q);
      end
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      ack = ~sda_line; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
      bit a;
      wbyte(b, 1'b0, a);
      check(req, 32'(a), 32'(exp_ack));
   endtask

   task automatic rd(input logic [7:0] exp, input bit ack_it, input string req);
      logic [7:0] v;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wait_clk(Q);
         scl_m = 1'b1; wait_clk(Q);
         v[i] = sda_line; wait_clk(Q);
         scl_m = 1'b0; wait_clk(Q);
      end
      rd_byte = v;
      -> rd_ev;
      sda_m = ~ack_it; wait_clk(Q);
      scl_m = 1'b1; wait_clk(2 * Q);
      scl_m = 1'b0; wait_clk(Q);
      sda_m = 1'b1;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      bit a;
      wait_clk(10);
      rst_n = 1'b1;
      wait_clk(4);
      // R7: reset state at the ports
      check("R7", 32'(tune_word), 32'h0);
      check("R7", 32'(comp_hold), 32'h0);
      check("R7", 32'(tune_updated), 32'h0);
      check("R5", 32'(sda_oe), 32'h0);

      // R7 / R4: read from reset pointer 00h
      bus_start();
      send(8'h83, 1'b1, "R1");
      rd(8'h00, 1'b1, "R7");
      rd(8'h00, 1'b1, "R7");
      rd(8'h19, 1'b1, "R7");
      rd(8'h00, 1'b0, "R7");
      bus_stop();

      // R6 / R10: write both trim bytes
      bus_start();
      send(8'h82, 1'b1, "R1");
      send(8'h00, 1'b1, "R2");
      send(8'hC5, 1'b1, "R3");
      send(8'h3A, 1'b1, "R3");
      bus_stop();
      check("R6", 32'(tune_word), 32'h453A);
      check("R6", 32'(comp_hold), 32'h1);
      check("R10", 32'(pulse_cnt), 32'd1);

      // R10: write to 00h alone gives no strobe
      bus_start();
      send(8'h82, 1'b1, "R1");
      send(8'h00, 1'b1, "R2");
      send(8'h12, 1'b1, "R3");
      bus_stop();
      check("R6", 32'(tune_word), 32'h123A);
      check("R6", 32'(comp_hold), 32'h0);
      check("R10", 32'(pulse_cnt), 32'd1);

      // R8 / R9 / R3: capture at word address, ignored writes, wrap
      temp_live = 12'hABC;
      bus_start();
      send(8'h82, 1'b1, "R1");
      send(8'h02, 1'b1, "R2");
      temp_live = 12'h123;
      send(8'h55, 1'b1, "R9");
      send(8'h66, 1'b1, "R9");
      send(8'h7F, 1'b1, "R3");
      bus_stop();
      check("R3", 32'(tune_word), 32'h7F3A);
      check("R10", 32'(pulse_cnt), 32'd1);

      // R4 / R8: read continues from pointer 01h and wraps
      bus_start();
      send(8'h83, 1'b1, "R1");
      rd(8'h3A, 1'b1, "R4");
      rd(8'hAB, 1'b1, "R8");
      rd(8'hC0, 1'b1, "R8");
      rd(8'h7F, 1'b0, "R4");
      wait_clk(Q);
      check("R5", 32'(sda_oe), 32'h0);
      bus_stop();

      // R2: out-of-range word address keeps low bits
      bus_start();
      send(8'h82, 1'b1, "R1");
      send(8'h05, 1'b1, "R2");
      send(8'h99, 1'b1, "R2");
      bus_stop();
      check("R2", 32'(tune_word), 32'h7F99);
      check("R10", 32'(pulse_cnt), 32'd2);

      // R8 / R4: new copy, pointer carried across reads
      bus_start();
      send(8'h83, 1'b1, "R1");
      rd(8'h12, 1'b1, "R8");
      rd(8'h30, 1'b0, "R8");
      bus_stop();
      bus_start();
      send(8'h83, 1'b1, "R1");
      rd(8'h7F, 1'b0, "R4");
      bus_stop();

      // R1: foreign address ignored until next START
      bus_start();
      send(8'h84, 1'b0, "R1");
      send(8'h01, 1'b0, "R1");
      send(8'hEE, 1'b0, "R1");
      bus_stop();
      check("R1", 32'(tune_word), 32'h7F99);
      check("R1", 32'(pulse_cnt), 32'd2);

      // R4: pointer write then repeated START into a read
      bus_start();
      send(8'h82, 1'b1, "R1");
      send(8'h01, 1'b1, "R2");
      bus_start();
      send(8'h83, 1'b1, "R1");
      rd(8'h99, 1'b0, "R4");
      bus_stop();

      // R11: short spikes on both lines during a data byte
      bus_start();
      send(8'h82, 1'b1, "R1");
      send(8'h00, 1'b1, "R2");
      wbyte(8'h2C, 1'b1, a);
      check("R11", 32'(a), 32'h1);
      bus_stop();
      check("R11", 32'(tune_word), 32'h2C99);
      check("R11", 32'(comp_hold), 32'h0);

      wait_clk(Q);
      check("R5", 32'(oe_viol), 32'd0);
      check("R4", 32'(exp_q.size()), 32'd0);
      summary();
      $finish;
   end
endmodule